// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is an independent watchdog. Once started, it counts down from a programmable reload value at a rate set by a selectable clock divider. If software lets the count run out, the block raises a one-cycle reset request and starts the count again from the reload value. Software refreshes the watchdog by writing a feed key. If that feed comes too early, while the count is still above a programmable window threshold, it is treated as a fault: the block raises the reset request straight away and does not reload the count.

All control goes through a small register port. A command register takes 16-bit key words. One key starts the counter, one feeds it, one unlocks the three configuration registers and one locks them again. The three configuration registers are the divider code, the reload value and the window value. Each has its own staging path with a busy flag. A new value only takes effect after a fixed settling delay, and the register keeps reading its old value until then. A status register and a live count register can be read back. After the counter has been started, no key can stop it. Only a reset returns the block to idle.

Top module: `keyed_window_wdt`

## Requirements
- R1: After reset the divider code reads 0, the reload and window registers read all ones (2^CNT_W-1), the count reads all ones, the status reads 0 and the reset request is low.
- R2: Command writes (address 0) act only for four keys: start 16'hA5C3, feed 16'h3C5A, unlock 16'h6E91 and lock 16'h1D2B. Any other value has no effect.
- R3: A write to the divider (address 1), reload (address 2) or window (address 3) register is ignored unless the unlock key has been given and has not since been cancelled by the lock key. An ignored write sets no busy flag and leaves the readback unchanged.
- R4: An accepted configuration write sets that register's own busy flag: status bit 0 for the divider, bit 1 for reload, bit 2 for window. The flag stays set for SYNC_DLY cycles. The register keeps reading its old value until the flag clears, and the new value appears in the same cycle the flag clears.
- R5: The divider keeps bits 2:0 of the written data. The reload and window registers keep bits CNT_W-1:0. Higher bits are dropped.
- R6: Divider code c sets a period of 4·2^c clock cycles per count step for c from 0 to 6. Code 7 behaves like code 6 (256).
- R7: After a start or feed with reload value R and divide ratio D, the reset request rises D·(R+1) cycles after the command edge. It is high for exactly one cycle, and the next request follows a further D·(R+1) cycles later.
- R8: A feed key that is not a window fault copies the reload value into the count (readable at address 5) and restarts the divider phase.
- R9: While running, a feed key given when the window is not all ones and the count is above the window value produces the reset request in the next cycle, and the count is not reloaded.
- R10: A window value of all ones disables the early-feed check, and a feed with the count at or below the window is accepted normally.
- R11: Once started, the counter keeps running whatever keys follow (status bit 4 stays set), and a further start key does not reload the count. Status bit 3 shows the unlock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 command, 1 divider, 2 reload, 3 window |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address: 1 divider, 2 reload, 3 window, 4 status, 5 count |
| rd_data | output | 16 | Combinational read data, zero-extended |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The bench builds the block with CNT_W = 6 and SYNC_DLY = 3, so the longest timeout, 256·64 cycles, stays short. This lets the bench sweep every divider code, including the aliased code 7, against reload values chosen to exercise single-step and multi-step periods, and measure both the first and the repeated timeout to the exact cycle. The small count range also lets it step feed points across each side of several window thresholds, and try the disabled window, in a few thousand cycles. With a three-cycle settling delay, every busy cycle of each configuration register can be checked one by one.

// File: rtl/wdg_pkg.sv
// Shared constants for the keyed watchdog: command keys and register addresses.
// Assumes a 16-bit command field and a 3-bit register address.
package wdg_pkg;
    localparam logic [15:0] KEY_START  = 16'hA5C3;
    localparam logic [15:0] KEY_FEED   = 16'h3C5A;
    localparam logic [15:0] KEY_UNLOCK = 16'h6E91;
    localparam logic [15:0] KEY_LOCK   = 16'h1D2B;

    localparam int PSC_CODE_W = 3;

    typedef enum logic [2:0] {
        A_CMD  = 3'd0,
        A_PSC  = 3'd1,
        A_RLD  = 3'd2,
        A_WIN  = 3'd3,
        A_STAT = 3'd4,
        A_CNT  = 3'd5
    } wdg_addr_e;
endpackage

// File: rtl/wdg_keydec.sv
// Key decoder: turns command-register writes into start/feed strobes and
// keeps the configuration unlock flag. Assumes cmd_we is already qualified
// by the command address. Unknown keys are dropped.
module wdg_keydec
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [15:0] cmd_data,
    output logic        start_stb,
    output logic        feed_stb,
    output logic        unlocked
);
    logic open_stb;
    logic shut_stb;

    // Match the written word against the four keys.
    always_comb begin
        start_stb = cmd_we && (cmd_data == KEY_START);
        feed_stb  = cmd_we && (cmd_data == KEY_FEED);
        open_stb  = cmd_we && (cmd_data == KEY_UNLOCK);
        shut_stb  = cmd_we && (cmd_data == KEY_LOCK);
    end

    // Hold the write-access state between unlock and lock keys.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (open_stb) begin
            unlocked <= 1'b1;
        end else if (shut_stb) begin
            unlocked <= 1'b0;
        end
    end
endmodule

// File: rtl/wdg_cfg_slot.sv
// One configuration register with a settling stage. An accepted write
// captures the data, raises busy for DLY cycles, then applies it.
// Assumes wr is already qualified by address and unlock. A write while busy
// replaces the staged value and restarts the delay. DLY >= 1.
module wdg_cfg_slot #(
    parameter int          W       = 12,
    parameter logic [W-1:0] RST_VAL = '1,
    parameter int          DLY     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         busy
);
    localparam int DLY_W = $clog2(DLY + 1);

    logic [W-1:0]     stage;
    logic [DLY_W-1:0] dly;

    // Stage the write, count down the settling delay, then apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RST_VAL;
            stage <= RST_VAL;
            dly   <= '0;
        end else if (wr) begin
            stage <= wdata;
            dly   <= DLY_W'(DLY);
        end else if (dly != '0) begin
            dly <= dly - 1'b1;
            if (dly == DLY_W'(1)) begin
                value <= stage;
            end
        end
    end

    // The flag reflects an update still in flight.
    assign busy = (dly != '0);
endmodule

// File: rtl/wdg_core.sv
// Countdown core: divider, down-counter, window check and reset pulse.
// Assumes start/feed are single-cycle strobes. The divider phase restarts
// on start and on an accepted feed. Running can only be cleared by reset.
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CNT_W        = 12,
    parameter int PSC_MIN_LOG  = 2,
    parameter int PSC_TOP_CODE = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  feed,
    input  logic [PSC_CODE_W-1:0] psc_code,
    input  logic [CNT_W-1:0]      reload,
    input  logic [CNT_W-1:0]      window,
    output logic                  running,
    output logic [CNT_W-1:0]      count,
    output logic                  rst_req
);
    localparam int PW = PSC_MIN_LOG + PSC_TOP_CODE;

    logic [PSC_CODE_W-1:0] shift;
    logic [PW:0]           div_full;
    logic [PW-1:0]         div_m1;
    logic [PW-1:0]         psc;
    logic                  tick;
    logic                  early;

    // Clamp the divider code and derive the terminal phase count.
    always_comb begin
        shift    = (psc_code > PSC_CODE_W'(PSC_TOP_CODE)) ? PSC_CODE_W'(PSC_TOP_CODE) : psc_code;
        div_full = (PW + 1)'(1 << PSC_MIN_LOG) << shift;
        div_m1   = PW'(div_full - 1'b1);
        tick     = running && (psc == div_m1);
        early    = running && !(&window) && (count > window);
    end

    // Advance divider and counter, handle keys, form the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            count   <= '1;
            psc     <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (running) begin
                psc <= tick ? '0 : PW'(psc + 1'b1);
            end
            if (feed && !early) begin
                count <= reload;
                psc   <= '0;
            end else if (tick) begin
                if (count == '0) begin
                    count   <= reload;
                    rst_req <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
            if (feed && early) begin
                rst_req <= 1'b1;
            end
            if (start && !running) begin
                running <= 1'b1;
                count   <= reload;
                psc     <= '0;
            end
        end
    end
endmodule

// File: rtl/keyed_window_wdt.sv
// Top level of the keyed windowed watchdog. Decodes the register port,
// gates configuration writes by the unlock state, holds the three staged
// configuration registers and the countdown core, and drives readback.
// Assumes 12 <= CNT_W <= 16 in production; any 3 <= CNT_W <= 16 works.
module keyed_window_wdt
    import wdg_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int SYNC_DLY = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        rst_req
);
    localparam int N_WIDE = 2;

    logic                  start_stb;
    logic                  feed_stb;
    logic                  unlocked;
    logic [2:0]            busy;
    logic [PSC_CODE_W-1:0] psc_val;
    logic [CNT_W-1:0]      wide_val [N_WIDE];
    logic                  run_q;
    logic [CNT_W-1:0]      count_q;

    wdg_keydec u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (wr_en && (wr_addr == A_CMD)),
        .cmd_data  (wr_data),
        .start_stb (start_stb),
        .feed_stb  (feed_stb),
        .unlocked  (unlocked)
    );

    wdg_cfg_slot #(
        .W       (PSC_CODE_W),
        .RST_VAL ('0),
        .DLY     (SYNC_DLY)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en && unlocked && (wr_addr == A_PSC)),
        .wdata (wr_data[PSC_CODE_W-1:0]),
        .value (psc_val),
        .busy  (busy[0])
    );

    // Reload and window share one slot shape at consecutive addresses.
    for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
        localparam logic [2:0] ADDR = 3'(int'(A_RLD) + i);
        wdg_cfg_slot #(
            .W       (CNT_W),
            .RST_VAL ('1),
            .DLY     (SYNC_DLY)
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_en && unlocked && (wr_addr == ADDR)),
            .wdata (wr_data[CNT_W-1:0]),
            .value (wide_val[i]),
            .busy  (busy[i+1])
        );
    end

    wdg_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_stb),
        .feed     (feed_stb),
        .psc_code (psc_val),
        .reload   (wide_val[0]),
        .window   (wide_val[1]),
        .running  (run_q),
        .count    (count_q),
        .rst_req  (rst_req)
    );

    // Select readback data by address.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_PSC:   rd_data = 16'(psc_val);
            A_RLD:   rd_data = 16'(wide_val[0]);
            A_WIN:   rd_data = 16'(wide_val[1]);
            A_STAT:  rd_data = {11'b0, run_q, unlocked, busy};
            A_CNT:   rd_data = 16'(count_q);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdg_checker.sv
// Protocol checks for the keyed watchdog, bound to the top level.
// Assumes the internal names unlocked, busy and run_q in the top module.
module wdg_checker
    import wdg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic       unlocked,
    input logic [2:0] busy,
    input logic       run_q,
    input logic       rst_req
);
    p_run_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> run_q);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !rst_req);

    p_locked_psc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_PSC) && !unlocked && !busy[0]) |=> !busy[0]);

    p_locked_rld_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_RLD) && !unlocked && !busy[1]) |=> !busy[1]);

    p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_WIN) && unlocked) |=> busy[2]);

    p_busy_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy[1]) |-> $past(wr_en && (wr_addr == A_RLD) && unlocked));
endmodule

bind keyed_window_wdt wdg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .unlocked (unlocked),
    .busy     (busy),
    .run_q    (run_q),
    .rst_req  (rst_req)
);

// File: tb/test_keyed_window_wdt.sv
// Self-checking bench for the keyed watchdog, built with CNT_W=6, SYNC_DLY=3.
module test_keyed_window_wdt;
    localparam int CW   = 6;
    localparam int DLY  = 3;
    localparam int MAXV = (1 << CW) - 1;
    localparam logic [15:0] K_START  = 16'hA5C3;
    localparam logic [15:0] K_FEED   = 16'h3C5A;
    localparam logic [15:0] K_UNLOCK = 16'h6E91;
    localparam logic [15:0] K_LOCK   = 16'h1D2B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    keyed_window_wdt #(.CNT_W(CW), .SYNC_DLY(DLY)) i_keyed_window_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic configure(input int code, input int rl, input int win);
        wr(3'd0, K_UNLOCK);
        wr(3'd1, 16'(code));
        wr(3'd2, 16'(rl));
        wr(3'd3, 16'(win));
        repeat (DLY + 2) @(posedge clk);
        #1;
    endtask

    function automatic int div_of(input int code);
        return 4 << ((code > 6) ? 6 : code);
    endfunction

    initial begin
        int v;
        int n;
        do_reset();

        // R1 reset state
        rd(3'd1, v); check(v == 0, "R1 divider", v, 0);
        rd(3'd2, v); check(v == MAXV, "R1 reload", v, MAXV);
        rd(3'd3, v); check(v == MAXV, "R1 window", v, MAXV);
        rd(3'd4, v); check(v == 0, "R1 status", v, 0);
        rd(3'd5, v); check(v == MAXV, "R1 count", v, MAXV);
        check(rst_req == 1'b0, "R1 rst_req", int'(rst_req), 0);

        // R3 locked writes ignored
        wr(3'd2, 16'd5);
        rd(3'd4, v); check(v == 0, "R3 no busy when locked", v, 0);
        repeat (DLY + 1) @(posedge clk);
        rd(3'd2, v); check(v == MAXV, "R3 locked reload", v, MAXV);
        wr(3'd0, K_UNLOCK);
        rd(3'd4, v); check(v == 8, "R11 unlock status bit", v, 8);
        wr(3'd0, K_LOCK);
        wr(3'd3, 16'd7);
        repeat (DLY + 1) @(posedge clk);
        rd(3'd3, v); check(v == MAXV, "R3 relocked window", v, MAXV);

        // R2 unknown key has no effect
        wr(3'd0, 16'h1234);
        rd(3'd4, v); check(v == 0, "R2 unknown key", v, 0);

        // R4/R5 busy flags and field masking, one register at a time
        wr(3'd0, K_UNLOCK);
        for (int i = 0; i < 3; i++) begin
            int oldv;
            int newv;
            logic [15:0] d;
            d = (i == 0) ? 16'hFFFD : ((i == 1) ? 16'hF0AB : 16'h1234);
            newv = (i == 0) ? 5 : ((i == 1) ? 43 : 52);
            oldv = (i == 0) ? 0 : MAXV;
            wr(3'(1 + i), d);
            rd(3'd4, v); check(v == (8 | (1 << i)), "R4 busy set", v, 8 | (1 << i));
            rd(3'(1 + i), v); check(v == oldv, "R4 old value while busy", v, oldv);
            for (int j = 1; j < DLY; j++) begin
                @(posedge clk); #1;
                rd(3'd4, v); check(v == (8 | (1 << i)), "R4 busy held", v, 8 | (1 << i));
            end
            @(posedge clk); #1;
            rd(3'd4, v); check(v == 8, "R4 busy cleared", v, 8);
            rd(3'(1 + i), v); check(v == newv, "R5 masked value", v, newv);
        end

        // R6/R7 timeout sweep over every divider code
        for (int code = 0; code < 8; code++) begin
            for (int k = 0; k < 2; k++) begin
                int rl;
                int exp;
                rl = (k == 0) ? 0 : 2;
                exp = div_of(code) * (rl + 1);
                do_reset();
                configure(code, rl, MAXV);
                wr(3'd0, K_START);
                n = 0;
                do begin @(posedge clk); #1; n++; end while (!rst_req);
                check(n == exp, "R6 R7 first timeout", n, exp);
                n = 0;
                @(posedge clk); #1; n++;
                check(rst_req == 1'b0, "R7 single-cycle pulse", int'(rst_req), 0);
                do begin @(posedge clk); #1; n++; end while (!rst_req);
                check(n == exp, "R7 repeat timeout", n, exp);
            end
        end

        // R8 feed reloads and restarts the period
        do_reset();
        configure(0, 10, MAXV);
        wr(3'd0, K_START);
        repeat (20) @(posedge clk);
        #1;
        check(rst_req == 1'b0, "R8 no early timeout", int'(rst_req), 0);
        wr(3'd0, K_FEED);
        rd(3'd5, v); check(v == 10, "R8 count reloaded", v, 10);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!rst_req);
        check(n == 44, "R8 period after feed", n, 44);

        // R9/R10 window sweep
        for (int w = 0; w < 3; w++) begin
            int win;
            win = (w == 0) ? 10 : ((w == 1) ? 20 : MAXV);
            for (int p = 0; p < 6; p++) begin
                int c;
                bit fault;
                c = (p == 0) ? 29 : (p == 1) ? 25 : (p == 2) ? 21 : (p == 3) ? 20 : (p == 4) ? 15 : 5;
                fault = (win != MAXV) && (c > win);
                do_reset();
                configure(0, 30, win);
                wr(3'd0, K_START);
                rd_addr = 3'd5;
                do begin @(posedge clk); #1; end while (int'(rd_data) != c);
                wr_en = 1'b1; wr_addr = 3'd0; wr_data = K_FEED;
                @(posedge clk);
                #1 wr_en = 1'b0;
                #1;
                check(rst_req == fault, "R9 R10 feed fault", int'(rst_req), int'(fault));
                v = int'(rd_data);
                if (fault)
                    check(v == c || v == c - 1, "R9 count not reloaded", v, c);
                else
                    check(v == 30, "R10 accepted feed reload", v, 30);
            end
        end

        // R11 keys cannot stop it; start while running does not reload
        do_reset();
        configure(7, 5, MAXV);
        wr(3'd0, K_START);
        wr(3'd2, 16'd40);
        repeat (DLY + 1) @(posedge clk);
        wr(3'd0, K_LOCK);
        wr(3'd0, 16'h0000);
        wr(3'd0, K_START);
        rd(3'd5, v); check(v == 5, "R11 restart ignored", v, 5);
        rd(3'd4, v); check(v == 16, "R11 still running", v, 16);
        wr(3'd0, K_FEED);
        rd(3'd5, v); check(v == 40, "R8 feed uses new reload", v, 40);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule